// File: doc/BRIEF.md
# Embedded-Clock Frame Serializer

This block turns a stream of 16-bit parallel words into a serial line in which each word is wrapped in an 18-bit frame. Every frame opens with a bit that is always high and closes with a bit that is always low. The closing low bit of one frame is followed by the opening high bit of the next, so a receiver always sees a rising edge at each frame boundary. It uses that edge to recover both bit timing and word alignment, with no line code applied to the payload.

The block runs on the transmit clock. A bit-rate clock enable, pulsed eighteen times per word period, moves the line forward by one bit. A new word is taken from the parallel bus at the edge where a frame starts, and a one-cycle strobe reports that edge. Holding the training input high at that point sends a fixed pattern instead of the payload, and the frame bits stay in place. Dropping the enable input idles the line at once. The next frame after reset or re-enable is always whole.

Top module: `clkbit_frame_tx`

## Requirements
- R1: A frame is 18 bits long, and the line advances one bit for each clock edge where `bit_tick` is high.
- R2: The first bit of every frame on the line is 1 and the last is 0.
- R3: The 16 payload bits follow the opening bit in order from `word_in[0]` to `word_in[15]`.
- R4: The payload is the value of `word_in` at the edge that starts the frame, and `word_taken` is high for the one cycle after that edge. Changes to `word_in` at any other time do not change the frame.
- R5: If `train_req` is high at the edge that starts the frame, the payload is eight 1s followed by eight 0s on the line, which is `16'h00FF` in word terms. The opening 1 and closing 0 are still sent.
- R6: `train_req` is sampled only at the edge that starts a frame, so no frame mixes payload and training bits.
- R7: When `tx_enable` is low at a clock edge, `ser_oe` and `ser_out` are 0 after that edge, and any partly sent frame is dropped.
- R8: After reset, or after `tx_enable` returns high, the first edge with `bit_tick` high starts a new frame, and `ser_oe` rises together with its opening bit.
- R9: While enabled, `ser_out` changes only at edges where `bit_tick` is high.
- R10: During and right after reset, `ser_oe`, `ser_out` and `word_taken` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | Bit-rate enable, 18 pulses per word |
| tx_enable | input | 1 | Enables the line when high; idles it when low |
| train_req | input | 1 | Requests the training pattern for the next frame |
| word_in | input | 16 | Parallel payload word |
| word_taken | output | 1 | High for one cycle after a word is captured |
| ser_out | output | 1 | Serial line data |
| ser_oe | output | 1 | Line drive enable; low means idle or high-impedance |

## Verification
The bench scrambles `word_in` and `train_req` for a few cycles right after each capture. A design that sampled them late or on every tick would then send frames mixing two words or mixing training and payload bits. It also runs the bit enable every cycle, every third cycle and in a pseudo-random pattern. A counter that stepped on the clock instead of the enable would produce short or stretched frames, and one that changed the line between ticks would break the hold check. Cutting `tx_enable` in the middle of a frame and bringing it back checks two things: a design that resumed the old frame, or left the line driven, would send a partial first frame or show a non-idle line.

// File: rtl/cfb_pkg.sv
package cfb_pkg;
    localparam int unsigned PAYLOAD_W_DEF = 16;
    localparam int unsigned FRAME_EXTRA   = 2;

    typedef struct packed {
        logic active;
        logic taken;
    } tx_state_t;
endpackage

// File: rtl/cfb_bit_index.sv
module cfb_bit_index #(
    parameter int unsigned FRAME_LEN = 18,
    localparam int unsigned IDX_W = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             at_last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } idx_state_t;

    idx_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d.idx = LAST_IDX;
        end else if (load) begin
            s_d.idx = '0;
        end else if (step && (s_q.idx != LAST_IDX)) begin
            s_d.idx = s_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.idx <= LAST_IDX;
        end else begin
            s_q <= s_d;
        end
    end

    assign idx     = s_q.idx;
    assign at_last = (s_q.idx == LAST_IDX);

    // R1
    idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.idx <= LAST_IDX);

    // R1
    load_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> (idx == '0));
endmodule

// File: rtl/cfb_frame_builder.sv
module cfb_frame_builder #(
    parameter int unsigned PAYLOAD_W = 16,
    localparam int unsigned FRAME_LEN = PAYLOAD_W + 2,
    localparam int unsigned HALF_W    = PAYLOAD_W / 2
) (
    input  logic [PAYLOAD_W-1:0] word,
    input  logic                 train,
    output logic [FRAME_LEN-1:0] frame
);
    logic [PAYLOAD_W-1:0] train_pat;
    logic [PAYLOAD_W-1:0] payload;

    for (genvar i = 0; i < PAYLOAD_W; i++) begin : g_pat
        assign train_pat[i] = (i < HALF_W) ? 1'b1 : 1'b0;
    end

    always_comb begin
        payload = train ? train_pat : word;
        frame   = {1'b0, payload, 1'b1};
    end
endmodule

// File: rtl/cfb_shifter.sv
module cfb_shifter #(
    parameter int unsigned FRAME_LEN = 18,
    localparam int unsigned REST_W = FRAME_LEN - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 load,
    input  logic                 step,
    input  logic [FRAME_LEN-1:0] frame,
    output logic                 line_bit
);
    typedef struct packed {
        logic              bit_o;
        logic [REST_W-1:0] rest;
    } sh_state_t;

    sh_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d.bit_o = 1'b0;
            s_d.rest  = '0;
        end else if (load) begin
            s_d.bit_o = frame[0];
            s_d.rest  = frame[FRAME_LEN-1:1];
        end else if (step) begin
            s_d.bit_o = s_q.rest[0];
            s_d.rest  = {1'b0, s_q.rest[REST_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign line_bit = s_q.bit_o;
endmodule

// File: rtl/clkbit_frame_tx.sv
module clkbit_frame_tx #(
    parameter int unsigned PAYLOAD_W = cfb_pkg::PAYLOAD_W_DEF,
    localparam int unsigned FRAME_LEN = PAYLOAD_W + cfb_pkg::FRAME_EXTRA,
    localparam int unsigned IDX_W     = $clog2(FRAME_LEN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_tick,
    input  logic                 tx_enable,
    input  logic                 train_req,
    input  logic [PAYLOAD_W-1:0] word_in,
    output logic                 word_taken,
    output logic                 ser_out,
    output logic                 ser_oe
);
    import cfb_pkg::*;

    tx_state_t s_d, s_q;

    logic                 start_frame;
    logic                 advance;
    logic                 at_last;
    logic [IDX_W-1:0]     bit_idx;
    logic [FRAME_LEN-1:0] next_frame;
    logic                 line_bit;

    // A frame starts on a tick when the line is idle or the last bit is out.
    always_comb begin
        start_frame = tx_enable && bit_tick && (!s_q.active || at_last);
        advance     = tx_enable && bit_tick && s_q.active && !at_last;
    end

    always_comb begin
        s_d = s_q;
        s_d.taken = start_frame;
        if (!tx_enable) begin
            s_d.active = 1'b0;
        end else if (start_frame) begin
            s_d.active = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    cfb_bit_index #(.FRAME_LEN(FRAME_LEN)) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!tx_enable),
        .load    (start_frame),
        .step    (advance),
        .idx     (bit_idx),
        .at_last (at_last)
    );

    cfb_frame_builder #(.PAYLOAD_W(PAYLOAD_W)) u_builder (
        .word  (word_in),
        .train (train_req),
        .frame (next_frame)
    );

    cfb_shifter #(.FRAME_LEN(FRAME_LEN)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!tx_enable),
        .load     (start_frame),
        .step     (advance),
        .frame    (next_frame),
        .line_bit (line_bit)
    );

    assign word_taken = s_q.taken;
    assign ser_out    = line_bit;
    assign ser_oe     = s_q.active;

    // R2
    open_bit_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_taken |-> (ser_out && ser_oe));

    // R2
    close_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_oe && at_last && (bit_idx != '0)) |-> !ser_out);

    // R7
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |=> (!ser_oe && !ser_out));

    // R9
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_enable && !bit_tick) |=> $stable(ser_out));

    // R8
    oe_rise_on_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_oe) |-> (word_taken && ser_out));
endmodule

// File: tb/clkbit_frame_tx_bench.sv
module clkbit_frame_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 16;
    localparam int FL = PW + 2;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_tick = 1'b0;
    logic          tx_enable = 1'b0;
    logic          train_req = 1'b0;
    logic [PW-1:0] word_in = '0;
    logic          word_taken, ser_out, ser_oe;

    clkbit_frame_tx u_clkbit_frame_tx (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_enable(tx_enable),
        .train_req(train_req), .word_in(word_in), .word_taken(word_taken),
        .ser_out(ser_out), .ser_oe(ser_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [FL-1:0] exp_q[$];
    logic [FL-1:0] obs;
    int            obs_cnt = 0;
    int            tick_mode = 0;
    int            train_mode = 0;
    int            scramble = 0;
    int            div_cnt = 0;
    int            frames_done = 0;
    logic [15:0]   lfsr = 16'hACE1;
    logic          edge_tick = 1'b0;
    logic          edge_en = 1'b0;
    logic          last_out = 1'b0;
    logic          last_oe = 1'b0;
    logic [PW-1:0] hold_word = 16'h1234;
    logic          hold_train = 1'b0;
    logic          train_toggle = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [FL-1:0] build_exp(input logic [PW-1:0] w, input logic t);
        return {1'b0, (t ? 16'h00FF : w), 1'b1};
    endfunction

    function automatic logic [15:0] step_lfsr(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // Monitor and driver share one process at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            // monitor: outputs now reflect the last rising edge
            if (edge_en && !edge_tick && ser_oe && last_oe)
                check(ser_out == last_out, "R9 hold", ser_out, last_out);
            if (!edge_en && !rst_n == 1'b0) begin
                check(!ser_oe && !ser_out, "R7 idle", {ser_oe, ser_out}, 0);
                if (obs_cnt > 0 && exp_q.size() > 0) begin
                    void'(exp_q.pop_front());
                    obs_cnt = 0;
                end
            end
            if (ser_oe && !last_oe)
                check(ser_out == 1'b1 && word_taken, "R8 first bit", {word_taken, ser_out}, 3);
            if (ser_oe && edge_tick) begin
                obs[obs_cnt] = ser_out;
                obs_cnt++;
                if (obs_cnt == FL) begin
                    obs_cnt = 0;
                    frames_done++;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R1 R4 frame with no capture", obs, 0);
                    end else begin
                        logic [FL-1:0] e;
                        e = exp_q.pop_front();
                        check(obs == e, "R1 R2 R3 R4 R5 R6 frame", obs, e);
                    end
                end
            end
            last_out = ser_out;
            last_oe  = ser_oe;

            // driver: record the captured word, then scramble and settle
            if (word_taken) begin
                exp_q.push_back(build_exp(word_in, train_req));
                train_toggle = ~train_toggle;
                hold_word  = lfsr;
                hold_train = (train_mode == 1) || (train_mode == 2 && train_toggle);
                scramble = 2;
            end
            lfsr = step_lfsr(lfsr);
            if (scramble > 0) begin
                word_in   = ~lfsr;
                train_req = lfsr[3];
                scramble--;
            end else begin
                word_in   = hold_word;
                train_req = hold_train;
            end
        end

        // bit enable pattern for the next edge
        lfsr = step_lfsr(lfsr);
        case (tick_mode)
            0: bit_tick = 1'b1;
            1: begin
                div_cnt  = (div_cnt == 2) ? 0 : div_cnt + 1;
                bit_tick = (div_cnt == 0);
            end
            default: bit_tick = lfsr[0] | lfsr[5];
        endcase
        edge_tick = bit_tick;
        edge_en   = tx_enable;
    end

    task automatic wait_frames(input int n);
        int target;
        target = frames_done + n;
        while (frames_done < target && !done) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        check(!ser_oe && !ser_out && !word_taken, "R10 in reset", {ser_oe, ser_out, word_taken}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(!ser_oe && !ser_out && !word_taken, "R10 after reset", {ser_oe, ser_out, word_taken}, 0);

        // R1 R3: plain words, tick every cycle
        tx_enable = 1'b1;
        tick_mode = 0;
        wait_frames(5);

        // R5 R6: training frames, then alternating
        train_mode = 1;
        wait_frames(3);
        train_mode = 2;
        wait_frames(4);
        train_mode = 0;

        // R9: tick every third cycle
        tick_mode = 1;
        wait_frames(3);

        // R7 R8: drop enable in mid-frame and come back
        tick_mode = 0;
        @(negedge clk);
        while (!word_taken) @(negedge clk);
        repeat (7) @(negedge clk);
        tx_enable = 1'b0;
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, "R7 dropped frame", exp_q.size(), 0);
        tx_enable = 1'b1;
        wait_frames(3);

        // pseudo-random ticks with mixed training
        tick_mode = 2;
        train_mode = 2;
        wait_frames(5);

        tx_enable = 1'b0;
        repeat (4) @(negedge clk);
        check(!ser_oe && !ser_out, "R7 final idle", {ser_oe, ser_out}, 0);
        done = 1'b1;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            done = 1'b1;
        end
    end

    initial begin
        wait (done);
        #(CLK_PERIOD);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule